// File: doc/BRIEF.md
# I2C Serial EEPROM Burst Master

This block is a single-master I2C controller for serial EEPROMs. One transaction moves a run of consecutive bytes, from 1 to 256, in either direction. The user raises a one-cycle start request and presents, in the same cycle, the direction, a 16-bit word address, an address-width select, the run length minus one and the first write byte. The block then sequences the whole bus transaction by itself. On the bus side it pulls SCL and SDA low through two output-enables and reads the SDA line back. An external pull-up provides the high level.

For a write, the block sends the device address, the word address and then the data bytes. After the first byte, it asks for each further byte with a one-cycle ready pulse. For a read, it first sends the device address and the word address as a write, then issues a repeated START and the device address with the read bit set. It then receives the bytes and hands each one out with a one-cycle valid strobe. Bit timing comes from an internal quarter-bit tick derived from the system clock. Any slave acknowledge slot that reads high sets a sticky no-acknowledge flag, which the next accepted start clears.

Top module: `i2c_burst_master`

## Requirements
- R1: After reset, and whenever the block is idle, scl_oe and sda_oe are 0, so both lines float high. busy, done, nack, wready and rvalid are 0 after reset.
- R2: A write transaction appears on the bus in this order: START, the byte {DEV_ADDR, 0}, the word address byte(s), then the data bytes, then STOP. Every byte is sent MSB first, and each is followed by one acknowledge slot in which the master releases SDA.
- R3: With addr16 = 1, word_addr[15:8] is sent and then word_addr[7:0]. With addr16 = 0, only word_addr[7:0] is sent.
- R4: A transaction moves exactly len_m1 + 1 data bytes, so the run length is 1 to 256. Written bytes land at consecutive EEPROM addresses, starting at the word address.
- R5: In a write of N bytes, wready pulses for one cycle exactly N-1 times. Each pulse asks for the next byte, and the byte on wdata is taken before the current byte's acknowledge slot ends. The first byte is taken together with start.
- R6: A read first sends START, {DEV_ADDR, 0} and the word address. It then sends a repeated START and {DEV_ADDR, 1}, then receives the bytes, then sends STOP.
- R7: During a read, the master drives SDA low (ACK) in the acknowledge slot of every received byte except the last. For the last byte it leaves SDA high (NACK), and then sends STOP.
- R8: Each received byte is presented on rdata with a one-cycle rvalid pulse, in bus order.
- R9: If SDA is high during any slave acknowledge slot, nack becomes 1 and stays 1 through done. An accepted start clears it.
- R10: SDA changes only while SCL is low, except for START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high).
- R11: After STOP, done pulses for one cycle. In that same cycle busy is 0 and both output-enables are 0.
- R12: A start request that arrives while busy is 1 is ignored. The bus sequence of the running transaction does not change, and no further transaction follows.
- R13: Each SCL high time lasts two quarter periods, where one quarter period is CLK_HZ / (4 * SCL_HZ) system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transaction (used only when idle) |
| rnw | input | 1 | 1 = read run, 0 = write run |
| word_addr | input | 16 | EEPROM word address of the first byte |
| addr16 | input | 1 | 1 = two-byte word address, 0 = one byte |
| len_m1 | input | LEN_W | Number of data bytes minus one |
| wdata | input | 8 | Write byte (first byte with start, later bytes after wready) |
| wready | output | 1 | One-cycle request for the next write byte |
| rdata | output | 8 | Last received byte |
| rvalid | output | 1 | One-cycle strobe marking a new rdata byte |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse after STOP |
| nack | output | 1 | Sticky flag: a slave acknowledge slot read high |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Level sampled on the SDA line |

## Verification
The bench runs a behavioural EEPROM slave on the wired-AND bus and decodes every START, STOP and byte edge by edge. It compares that log with the frame the requirements predict, so an address sent in the wrong byte order, a missing repeated START, or an SDA edge while SCL is high appears as an extra or misplaced event. The bench tests both run-length extremes. A one-byte read must NACK its only byte at once, and a design that ACKs it would show a wrong acknowledge pattern. A 256-byte run wraps the slave pointer, and a design that counts one byte too many or too few would shift every following byte. The bench also injects a slave NACK to show that the flag stays set and is cleared only at the next start. It raises start mid-transaction to catch a design that restarts or queues a second transaction.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  // kind of bus slot the bit engine runs
  typedef enum logic [1:0] {
    SL_START,
    SL_STOP,
    SL_TX,
    SL_RX
  } slot_e;

  // transaction sequencer position
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_DEVW,
    ST_AHI,
    ST_ALO,
    ST_RSTART,
    ST_DEVR,
    ST_WR,
    ST_RD,
    ST_STOP
  } seq_e;
endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
  parameter int CLK_HZ = 50_000_000,
  parameter int SCL_HZ = 250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int QDIV = CLK_HZ / (4 * SCL_HZ);
  localparam int CW   = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(QDIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cb_slot.sv
module i2cb_slot
  import i2cb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       go,
  input  slot_e      kind,
  input  logic [7:0] tx_byte,
  input  logic       ack_drv,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       fin,
  output logic [7:0] rx_byte,
  output logic       slv_nack
);
  logic       active;
  slot_e      kind_r;
  logic [3:0] bitn;
  logic [1:0] ph;
  logic [7:0] sh;
  logic       ack_r;
  logic       short_slot;
  logic       last_q;

  assign short_slot = (kind_r == SL_START) || (kind_r == SL_STOP);
  assign last_q     = (ph == 2'd3) && (short_slot || bitn == 4'd8);
  assign rx_byte    = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      kind_r   <= SL_START;
      bitn     <= '0;
      ph       <= '0;
      sh       <= '0;
      ack_r    <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      fin      <= 1'b0;
      slv_nack <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          kind_r <= kind;
          bitn   <= '0;
          ph     <= '0;
          sh     <= tx_byte;
          ack_r  <= ack_drv;
        end
      end else if (tick) begin
        ph <= ph + 2'd1;
        if (ph == 2'd3) bitn <= bitn + 4'd1;
        if (last_q) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
        case (kind_r)
          SL_START: begin
            case (ph)
              2'd0:    sda_oe <= 1'b0;
              2'd1:    scl_oe <= 1'b0;
              2'd2:    sda_oe <= 1'b1;
              default: scl_oe <= 1'b1;
            endcase
          end
          SL_STOP: begin
            case (ph)
              2'd0: begin
                scl_oe <= 1'b1;
                sda_oe <= 1'b1;
              end
              2'd1:    scl_oe <= 1'b0;
              2'd2:    sda_oe <= 1'b0;
              default: ;
            endcase
          end
          default: begin
            case (ph)
              2'd0: begin
                scl_oe <= 1'b1;
                if (bitn == 4'd8) sda_oe <= (kind_r == SL_RX) && ack_r;
                else              sda_oe <= (kind_r == SL_TX) && !sh[7];
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (bitn == 4'd8) begin
                  if (kind_r == SL_TX) slv_nack <= sda_in;
                end else begin
                  sh <= {sh[6:0], sda_in};
                end
              end
              default: scl_oe <= 1'b1;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_burst_master.sv
module i2c_burst_master
  import i2cb_pkg::*;
#(
  parameter int         CLK_HZ   = 50_000_000,
  parameter int         SCL_HZ   = 250_000,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rnw,
  input  logic [15:0]      word_addr,
  input  logic             addr16,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [7:0]       wdata,
  output logic             wready,
  output logic [7:0]       rdata,
  output logic             rvalid,
  output logic             busy,
  output logic             done,
  output logic             nack,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  seq_e             state;
  logic             pend;
  logic             go_r;
  slot_e            kind_q;
  logic [7:0]       txb_q;
  logic             ackd_q;
  logic [LEN_W-1:0] rem;
  logic [7:0]       cur;
  logic [15:0]      addr_r;
  logic             a16_r;
  logic             rnw_r;
  logic             tick;
  logic             eng_fin;
  logic             eng_nack;
  logic [7:0]       eng_rx;
  slot_e            slot_k;
  logic [7:0]       slot_b;

  i2cb_qtick #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (busy),
    .tick(tick)
  );

  i2cb_slot u_slot (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .go      (go_r),
    .kind    (kind_q),
    .tx_byte (txb_q),
    .ack_drv (ackd_q),
    .sda_in  (sda_in),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .fin     (eng_fin),
    .rx_byte (eng_rx),
    .slv_nack(eng_nack)
  );

  // slot kind and outgoing byte for the current sequencer position
  always_comb begin
    case (state)
      ST_START, ST_RSTART: slot_k = SL_START;
      ST_STOP:             slot_k = SL_STOP;
      ST_RD:               slot_k = SL_RX;
      default:             slot_k = SL_TX;
    endcase
    case (state)
      ST_DEVW: slot_b = {DEV_ADDR, 1'b0};
      ST_AHI:  slot_b = addr_r[15:8];
      ST_ALO:  slot_b = addr_r[7:0];
      ST_DEVR: slot_b = {DEV_ADDR, 1'b1};
      default: slot_b = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pend   <= 1'b0;
      go_r   <= 1'b0;
      kind_q <= SL_START;
      txb_q  <= '0;
      ackd_q <= 1'b0;
      rem    <= '0;
      cur    <= '0;
      addr_r <= '0;
      a16_r  <= 1'b0;
      rnw_r  <= 1'b0;
      wready <= 1'b0;
      rdata  <= '0;
      rvalid <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      nack   <= 1'b0;
    end else begin
      go_r   <= 1'b0;
      wready <= 1'b0;
      rvalid <= 1'b0;
      done   <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state  <= ST_START;
          busy   <= 1'b1;
          nack   <= 1'b0;
          pend   <= 1'b0;
          addr_r <= word_addr;
          a16_r  <= addr16;
          rnw_r  <= rnw;
          rem    <= len_m1;
          cur    <= wdata;
        end
      end else if (!pend) begin
        go_r   <= 1'b1;
        pend   <= 1'b1;
        kind_q <= slot_k;
        txb_q  <= slot_b;
        ackd_q <= (rem != '0);
        if (state == ST_WR && rem != '0) wready <= 1'b1;
      end else if (eng_fin) begin
        pend <= 1'b0;
        if (kind_q == SL_TX && eng_nack) nack <= 1'b1;
        case (state)
          ST_START:  state <= ST_DEVW;
          ST_DEVW:   state <= a16_r ? ST_AHI : ST_ALO;
          ST_AHI:    state <= ST_ALO;
          ST_ALO:    state <= rnw_r ? ST_RSTART : ST_WR;
          ST_RSTART: state <= ST_DEVR;
          ST_DEVR:   state <= ST_RD;
          ST_WR: begin
            cur <= wdata;
            if (rem == '0) state <= ST_STOP;
            else           rem   <= rem - 1'b1;
          end
          ST_RD: begin
            rdata  <= eng_rx;
            rvalid <= 1'b1;
            if (rem == '0) state <= ST_STOP;
            else           rem   <= rem - 1'b1;
          end
          ST_STOP: begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic nack,
  input logic wready,
  input logic rvalid,
  input logic scl_oe,
  input logic sda_oe
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));

  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !scl_oe && !sda_oe));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  nack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !nack);

  // R5
  wready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wready |-> (busy && !rvalid));

  // R8
  rvalid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> busy);

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind i2c_burst_master i2cb_chk u_chk (.*);

// File: tb/i2c_burst_master_bench.sv
module i2c_burst_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int SCL_HZ     = 250_000;
  localparam int QDIV       = CLK_HZ / (4 * SCL_HZ);
  localparam int EV_START   = 256;
  localparam int EV_STOP    = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rnw = 1'b0;
  logic [15:0] word_addr = '0;
  logic        addr16 = 1'b0;
  logic [7:0]  len_m1 = '0;
  logic [7:0]  wdata = '0;
  logic        wready, rvalid, busy, done, nack, scl_oe, sda_oe;
  logic [7:0]  rdata;
  logic        slv_pull = 1'b0;
  logic        sda_line;

  assign sda_line = !sda_oe && !slv_pull;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_burst_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_i2c_burst_master (
    .clk(clk), .rst(rst), .start(start), .rnw(rnw), .word_addr(word_addr),
    .addr16(addr16), .len_m1(len_m1), .wdata(wdata), .wready(wready),
    .rdata(rdata), .rvalid(rvalid), .busy(busy), .done(done), .nack(nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int n_chk = 0;
  int n_fail = 0;
  int bus_log[$];
  int mack_log[$];
  int rd_log[$];
  int wbuf[256];
  logic [7:0] smem[256];
  int slv_na = 1;
  int slv_nack_at = -1;
  int ack_slot_cnt = 0;
  int hi_viol = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural EEPROM slave and bus decoder, evaluated every clock
  logic scl_p = 1'b1, sda_p = 1'b1, scl_n;
  int   sst = 0, sbit = 0, sidx = 0, rise_t = -1, cyc = 0;
  logic [7:0] ssh = '0, scur = '0, sptr = '0;
  logic srw = 1'b0, sack = 1'b0;

  always @(negedge clk) begin
    cyc++;
    scl_n = !scl_oe;
    if (rst) begin
      sst = 0; slv_pull = 1'b0; scl_p = 1'b1; sda_p = 1'b1; rise_t = -1;
    end else begin
      if (scl_n && scl_p && sda_p && !sda_line) begin
        bus_log.push_back(EV_START);
        sst = 1; sbit = 0; sidx = 0; slv_pull = 1'b0;
      end else if (scl_n && scl_p && !sda_p && sda_line) begin
        bus_log.push_back(EV_STOP);
        sst = 0; slv_pull = 1'b0; rise_t = -1;
      end else if (scl_n && !scl_p) begin
        rise_t = cyc;
        if (sst == 1) begin
          ssh = {ssh[6:0], sda_line}; sbit++;
        end else if (sst == 4) begin
          sack = sda_line; mack_log.push_back(int'(sda_line));
        end
      end else if (!scl_n && scl_p) begin
        if (rise_t >= 0 && cyc - rise_t != 2 * QDIV) hi_viol++;
        rise_t = -1;
        case (sst)
          1: if (sbit == 8) begin
            bus_log.push_back(int'(ssh));
            if (sidx == 0) srw = ssh[0];
            else if (sidx <= slv_na) sptr = ssh;
            else begin smem[sptr] = ssh; sptr = sptr + 8'd1; end
            sidx++;
            slv_pull = (ack_slot_cnt != slv_nack_at);
            ack_slot_cnt++;
            sst = 2;
          end
          2: begin
            slv_pull = 1'b0;
            sbit = 0;
            if (sidx == 1 && srw) begin
              sst = 3; scur = smem[sptr]; slv_pull = !scur[7];
            end else sst = 1;
          end
          3: begin
            sbit++;
            if (sbit == 8) begin slv_pull = 1'b0; sst = 4; end
            else slv_pull = !scur[7 - sbit];
          end
          4: begin
            sptr = sptr + 8'd1;
            if (!sack) begin
              sst = 3; scur = smem[sptr]; sbit = 0; slv_pull = !scur[7];
            end else begin
              sst = 0; slv_pull = 1'b0;
            end
          end
          default: ;
        endcase
      end
      scl_p = scl_n;
      sda_p = !sda_oe && !slv_pull;
    end
  end

  task automatic cmp_log(input int exp[$], input string tag);
    int bad = -1;
    if (exp.size() != bus_log.size()) bad = 0;
    else foreach (exp[i]) if (bad < 0 && exp[i] != bus_log[i]) bad = i;
    chk(bad < 0, tag, (bad >= 0 && bad < bus_log.size()) ? bus_log[bad] : bus_log.size(),
        (bad >= 0 && bad < exp.size()) ? exp[bad] : exp.size());
  endtask

  task automatic run_txn(input bit rd, input logic [15:0] a, input bit a16, input int n,
                         input int base, input int nack_at, input bit poke);
    int exp[$];
    int exp_rd[$];
    int k = 1, pulses = 0, wc = 0;
    bit fin = 0, late_busy = 0;
    bus_log.delete(); mack_log.delete(); rd_log.delete();
    slv_na = a16 ? 2 : 1; ack_slot_cnt = 0; slv_nack_at = nack_at; hi_viol = 0;
    for (int i = 0; i < n; i++) wbuf[i] = (base + i * 29) & 255;
    for (int i = 0; i < n; i++) exp_rd.push_back(int'(smem[8'(a[7:0] + i)]));
    exp.push_back(EV_START); exp.push_back(8'hA0);
    if (a16) exp.push_back(int'(a[15:8]));
    exp.push_back(int'(a[7:0]));
    if (rd) begin
      exp.push_back(EV_START); exp.push_back(8'hA1);
    end else for (int i = 0; i < n; i++) exp.push_back(wbuf[i]);
    exp.push_back(EV_STOP);

    @(negedge clk);
    start = 1'b1; rnw = rd; word_addr = a; addr16 = a16; len_m1 = 8'(n - 1); wdata = 8'(wbuf[0]);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after accepted start", busy, 1);
    chk(nack == 1'b0, "R9 nack cleared by start", nack, 0);
    while (!fin) begin
      @(negedge clk);
      start = 1'b0;
      if (wready) begin
        pulses++;
        if (k < n) wdata = 8'(wbuf[k]);
        k++;
      end
      if (rvalid) rd_log.push_back(int'(rdata));
      if (poke && wc == 60) begin
        start = 1'b1; rnw = !rd; word_addr = 16'h0033; len_m1 = 8'd0;
      end
      wc++;
      if (done) begin
        fin = 1;
        chk(!busy && !scl_oe && !sda_oe, "R11 released at done",
            {busy, scl_oe, sda_oe}, 0);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", done, 0);
    chk(nack == (nack_at >= 0), "R9 sticky nack at end", nack, nack_at >= 0);
    chk(hi_viol == 0, "R13 SCL high time", hi_viol, 0);
    cmp_log(exp, rd ? "R6 R3 R10 read frame" : "R2 R3 R10 write frame");
    if (rd) begin
      bit ok = (rd_log.size() == n);
      bit aok = (mack_log.size() == n);
      chk(ok, "R4 read byte count", rd_log.size(), n);
      if (ok) foreach (exp_rd[i]) chk(rd_log[i] == exp_rd[i], "R8 read data", rd_log[i], exp_rd[i]);
      chk(aok, "R7 master ack slots", mack_log.size(), n);
      if (aok) foreach (mack_log[i])
        chk(mack_log[i] == (i == n - 1), "R7 master ack level", mack_log[i], i == n - 1);
      chk(pulses == 0, "R5 no wready on read", pulses, 0);
    end else begin
      int bad = 0;
      chk(pulses == n - 1, "R5 wready pulse count", pulses, n - 1);
      for (int i = 0; i < n; i++) if (smem[8'(a[7:0] + i)] != 8'(wbuf[i])) bad++;
      chk(bad == 0, "R4 bytes stored at consecutive addresses", bad, 0);
    end
    if (poke) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy || scl_oe || sda_oe) late_busy = 1;
      end
      chk(!late_busy, "R12 start while busy ignored", late_busy, 0);
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 190_000) begin
      n_fail++;
      $display("FAIL R11 watchdog expired actual=%0d expected<%0d", wd, 190_000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) smem[i] = 8'(i) ^ 8'h3C;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !nack, "R1 status after reset", {busy, done, nack}, 0);
    chk(!wready && !rvalid, "R1 strobes after reset", {wready, rvalid}, 0);

    run_txn(0, 16'h0010, 0, 3, 8'h5A, -1, 0);
    run_txn(0, 16'h1234, 1, 5, 8'h11, -1, 0);
    run_txn(1, 16'h0010, 1, 3, 0, -1, 0);
    run_txn(1, 16'h0034, 0, 1, 0, -1, 0);
    run_txn(0, 16'h0080, 0, 2, 8'hE1, 2, 0);
    run_txn(1, 16'h0080, 0, 2, 0, -1, 0);
    run_txn(0, 16'h0040, 0, 4, 8'h07, -1, 1);
    run_txn(0, 16'h0000, 0, 256, 8'h90, -1, 0);
    run_txn(1, 16'h0580, 1, 256, 0, -1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule